// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It reads a 32-bit instruction word that a neighbouring instruction memory returns for the current program counter. It decodes the opcode into a set of control lines and carries out the operation against a 32-entry register file and a 32-word data store held inside the block. The instruction set covers register-register arithmetic and logic, add-immediate, load-upper-immediate, word load and store, plain jump, jump-and-link and jump-through-register.

The choice of the following address is left to a separate next-PC unit. The core presents the decoded branch, jump and register-jump controls, the ALU zero flag and the first source operand to that unit. It loads whatever address the unit returns on the next rising edge. Every register-file write the core attempts appears on a debug port with its destination and data.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc` is 0, register 29 holds 128 and every other register holds 0.
- R2: Out of reset, `pc` takes the value of `pc_next` at each rising clock edge.
- R3: With opcode 6'b000000, funct 6'b100000 writes rs+rt, 6'b100010 writes rs-rt, 6'b100100 writes rs AND rt, 6'b100101 writes rs OR rt and 6'b101010 writes 1 if rs < rt as signed numbers (else 0). The destination is rd (bits 15:11).
- R4: addi (opcode 6'b001000) writes rs plus the sign-extended imm (bits 15:0) into rt (bits 20:16). lui (opcode 6'b001111) writes {imm, 16'h0000} into rt.
- R5: sw (opcode 6'b101101) stores rt into the data word selected by bits 6:2 of rs + sign-extended imm and raises no register write.
- R6: lw (opcode 6'b101100) writes the data word selected by bits 6:2 of rs + sign-extended imm into rt.
- R7: jal (opcode 6'b000011) writes pc+4 into register 31 and raises `ctl_jump`. j (opcode 6'b000010) raises `ctl_jump` and writes nothing. Address field is bits 25:0.
- R8: jr (opcode 0, funct 6'b001000) raises `ctl_jreg`, shows the rs value on `rs_value` and writes nothing.
- R9: A write aimed at register 0 is reported on the debug port but leaves register 0 reading as 0.
- R10: beq (opcode 6'b001010) and bne (opcode 6'b001011) raise `ctl_branch`, write nothing, and `alu_zero` is 1 exactly when rs equals rt.
- R11: An opcode outside the listed set raises no write, no jump and no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word at `pc` |
| pc_next | input | 32 | Address chosen by the next-PC unit |
| pc | output | 32 | Current program counter |
| ctl_branch | output | 1 | Conditional branch decoded |
| ctl_jump | output | 1 | j or jal decoded |
| ctl_jreg | output | 1 | jr decoded |
| alu_zero | output | 1 | ALU result is zero |
| rs_value | output | 32 | First source operand |
| wb_en | output | 1 | Register write attempted this cycle |
| wb_addr | output | 5 | Write destination |
| wb_data | output | 32 | Write data |

## Verification
The data store and the register file have no direct port. A store is only visible once a later load returns the stored word, so the program stores two values at offsets on both sides of the stack pointer and loads them back into fresh registers. The jump-through-register path needs a return address that only jal creates. The bench therefore plays the next-PC unit: it jumps forward with jal, returns with jr r31, and checks the linked value, the reported operand and the resulting address sequence.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int DMEM_WORDS = 32,
  parameter logic [31:0] SP_RESET = 32'd128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic [31:0] pc_next,
  output logic [31:0] pc,
  output logic        ctl_branch,
  output logic        ctl_jump,
  output logic        ctl_jreg,
  output logic        alu_zero,
  output logic [31:0] rs_value,
  output logic        wb_en,
  output logic [4:0]  wb_addr,
  output logic [31:0] wb_data
);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_R    = 6'b000000;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_LUI  = 6'b001111;
  localparam logic [5:0] OP_LW   = 6'b101100;
  localparam logic [5:0] OP_SW   = 6'b101101;
  localparam logic [5:0] OP_BEQ  = 6'b001010;
  localparam logic [5:0] OP_BNE  = 6'b001011;
  localparam logic [5:0] OP_J    = 6'b000010;
  localparam logic [5:0] OP_JAL  = 6'b000011;
  localparam logic [5:0] FN_JR   = 6'b001000;

  logic [5:0]  op, fn;
  logic [4:0]  ra, rb, rd;
  logic [31:0] simm, rt_value, alu_b, alu_y, mem_q, pc_plus4;
  logic        reg_dst, alu_src, reg_write, mem_rd, mem_wr, mem_to_reg, is_link;
  logic [2:0]  alu_op;
  logic [31:0] rf [32];
  logic [31:0] dm [DMEM_WORDS];

  assign op   = instr[31:26];
  assign ra   = instr[25:21];
  assign rb   = instr[20:16];
  assign rd   = instr[15:11];
  assign fn   = instr[5:0];
  assign simm = {{16{instr[15]}}, instr[15:0]};
  assign pc_plus4 = pc + 32'd4;

  always_comb begin
    reg_dst = 1'b0; alu_src = 1'b0; reg_write = 1'b0; mem_rd = 1'b0;
    mem_wr = 1'b0; mem_to_reg = 1'b0; ctl_branch = 1'b0; ctl_jump = 1'b0;
    ctl_jreg = 1'b0; is_link = 1'b0; alu_op = 3'b000;
    unique case (op)
      OP_R: begin
        alu_op = 3'b010;
        if (fn == FN_JR) ctl_jreg = 1'b1;
        else begin reg_dst = 1'b1; reg_write = 1'b1; end
      end
      OP_ADDI: begin alu_op = 3'b100; alu_src = 1'b1; reg_write = 1'b1; end
      OP_LUI:  begin alu_op = 3'b101; alu_src = 1'b1; reg_write = 1'b1; end
      OP_LW: begin
        alu_src = 1'b1; mem_rd = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1;
      end
      OP_SW:   begin alu_src = 1'b1; mem_wr = 1'b1; end
      OP_BEQ:  begin alu_op = 3'b001; ctl_branch = 1'b1; end
      OP_BNE:  begin alu_op = 3'b110; ctl_branch = 1'b1; end
      OP_J:    ctl_jump = 1'b1;
      OP_JAL:  begin ctl_jump = 1'b1; is_link = 1'b1; reg_write = 1'b1; end
      default: ;
    endcase
  end

  assign rs_value = (ra == 5'd0) ? 32'd0 : rf[ra];
  assign rt_value = (rb == 5'd0) ? 32'd0 : rf[rb];
  assign alu_b    = alu_src ? simm : rt_value;

  always_comb begin
    unique case (alu_op)
      3'b000, 3'b100: alu_y = rs_value + alu_b;
      3'b001, 3'b110: alu_y = rs_value - alu_b;
      3'b101:         alu_y = {instr[15:0], 16'h0000};
      3'b010: begin
        unique case (fn)
          6'b100000: alu_y = rs_value + alu_b;
          6'b100010: alu_y = rs_value - alu_b;
          6'b100100: alu_y = rs_value & alu_b;
          6'b100101: alu_y = rs_value | alu_b;
          6'b101010: alu_y = {31'd0, $signed(rs_value) < $signed(alu_b)};
          default:   alu_y = 32'd0;
        endcase
      end
      default: alu_y = 32'd0;
    endcase
  end
  assign alu_zero = (alu_y == 32'd0);

  assign mem_q   = dm[alu_y[DAW+1:2]];
  assign wb_en   = reg_write;
  assign wb_addr = is_link ? 5'd31 : (reg_dst ? rd : rb);
  assign wb_data = is_link ? pc_plus4 : (mem_to_reg ? mem_q : alu_y);

  always_ff @(posedge clk) begin
    if (mem_wr) dm[alu_y[DAW+1:2]] <= rt_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= (i == 29) ? SP_RESET : 32'd0;
    end else begin
      pc <= pc_next;
      if (wb_en && wb_addr != 5'd0) rf[wb_addr] <= wb_data;
    end
  end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] pc_next,
  input logic [5:0]  op,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        ctl_jreg,
  input logic        ctl_jump,
  input logic        ctl_branch,
  input logic        wb_en,
  input logic [4:0]  wb_addr,
  input logic [31:0] wb_data
);
  a_r2_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pc == $past(pc_next));
  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !wb_en && !mem_rd);
  a_r8_jr_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_jreg |-> !wb_en && !ctl_jump);
  a_r7_jal_link: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'b000011) |-> wb_en && wb_addr == 5'd31 && wb_data == pc + 32'd4);
  a_r10_branch_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_branch |-> !wb_en && !mem_wr && !ctl_jump);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .pc_next(pc_next), .op(op),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .ctl_jreg(ctl_jreg), .ctl_jump(ctl_jump),
  .ctl_branch(ctl_branch), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] instr, pc_next, pc, rs_value, wb_data;
  logic ctl_branch, ctl_jump, ctl_jreg, alu_zero, wb_en;
  logic [4:0] wb_addr;
  logic [31:0] prog [32];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sc_core dut (.clk(clk), .rst_n(rst_n), .instr(instr), .pc_next(pc_next),
    .pc(pc), .ctl_branch(ctl_branch), .ctl_jump(ctl_jump), .ctl_jreg(ctl_jreg),
    .alu_zero(alu_zero), .rs_value(rs_value), .wb_en(wb_en), .wb_addr(wb_addr),
    .wb_data(wb_data));

  // next-PC neighbour model
  assign instr   = prog[pc[6:2]];
  assign pc_next = ctl_jreg ? rs_value :
                   ctl_jump ? {pc[31:28] + 4'd0, instr[25:0], 2'b00} : pc + 32'd4;

  function automatic logic [31:0] rr(input logic [4:0] s, t, d, input logic [5:0] f);
    return {6'b0, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] o, input logic [4:0] s, t, input logic [15:0] m);
    return {o, s, t, m};
  endfunction
  function automatic logic [31:0] jj(input logic [5:0] o, input logic [25:0] a);
    return {o, a};
  endfunction

  // {pc, wb_en, wb_addr, wb_data}
  localparam logic [69:0] TRACE [23] = '{
    {32'd0,  1'b1, 5'd1,  32'd5},        {32'd4,  1'b1, 5'd2,  32'hFFFFFFFD},
    {32'd8,  1'b1, 5'd3,  32'd2},        {32'd12, 1'b1, 5'd4,  32'd8},
    {32'd16, 1'b1, 5'd5,  32'd5},        {32'd20, 1'b1, 5'd6,  32'hFFFFFFFD},
    {32'd24, 1'b1, 5'd7,  32'd1},        {32'd28, 1'b1, 5'd8,  32'd0},
    {32'd32, 1'b1, 5'd9,  32'h12340000}, {32'd36, 1'b0, 5'd0,  32'd0},
    {32'd40, 1'b0, 5'd0,  32'd0},        {32'd44, 1'b1, 5'd10, 32'd5},
    {32'd48, 1'b1, 5'd11, 32'd2},        {32'd52, 1'b1, 5'd0,  32'd7},
    {32'd56, 1'b1, 5'd12, 32'd0},        {32'd60, 1'b1, 5'd13, 32'd128},
    {32'd64, 1'b1, 5'd31, 32'd68},       {32'd80, 1'b0, 5'd0,  32'd0},
    {32'd68, 1'b1, 5'd14, 32'd1},        {32'd72, 1'b0, 5'd0,  32'd0},
    {32'd88, 1'b0, 5'd0,  32'd0},        {32'd92, 1'b0, 5'd0,  32'd0},
    {32'd96, 1'b0, 5'd0,  32'd0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 8: return "R4";
      2, 3, 4, 5, 6, 7: return "R3";
      9, 10: return "R5";
      11, 12: return "R6";
      13, 14: return "R9";
      15: return "R1";
      16, 19: return "R7";
      17: return "R8";
      20, 21: return "R10";
      22: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    for (int k = 0; k < 32; k++) prog[k] = 32'hFC000000;
    prog[0]  = ii(6'b001000, 0, 1, 16'd5);
    prog[1]  = ii(6'b001000, 0, 2, 16'hFFFD);
    prog[2]  = rr(1, 2, 3, 6'b100000);
    prog[3]  = rr(1, 2, 4, 6'b100010);
    prog[4]  = rr(1, 2, 5, 6'b100100);
    prog[5]  = rr(1, 2, 6, 6'b100101);
    prog[6]  = rr(2, 1, 7, 6'b101010);
    prog[7]  = rr(1, 2, 8, 6'b101010);
    prog[8]  = ii(6'b001111, 0, 9, 16'h1234);
    prog[9]  = ii(6'b101101, 29, 1, 16'd4);
    prog[10] = ii(6'b101101, 29, 3, 16'hFFF8);
    prog[11] = ii(6'b101100, 29, 10, 16'd4);
    prog[12] = ii(6'b101100, 29, 11, 16'hFFF8);
    prog[13] = ii(6'b001000, 0, 0, 16'd7);
    prog[14] = rr(0, 0, 12, 6'b100000);
    prog[15] = rr(29, 0, 13, 6'b100000);
    prog[16] = jj(6'b000011, 26'd20);
    prog[17] = ii(6'b001000, 0, 14, 16'd1);
    prog[18] = jj(6'b000010, 26'd22);
    prog[20] = rr(31, 0, 0, 6'b001000);
    prog[22] = ii(6'b001010, 1, 1, 16'd3);
    prog[23] = ii(6'b001011, 1, 2, 16'd3);
    prog[24] = 32'hFC2A0004;

    repeat (3) @(negedge clk);
    #1 chk("R1", "pc in reset", pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 23; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      chk(tag_of(i), "pc", pc, TRACE[i][69:38]);
      chk(tag_of(i), "wb_en", {31'd0, wb_en}, {31'd0, TRACE[i][37]});
      if (TRACE[i][37]) begin
        chk(tag_of(i), "wb_addr", {27'd0, wb_addr}, {27'd0, TRACE[i][36:32]});
        chk(tag_of(i), "wb_data", wb_data, TRACE[i][31:0]);
      end
      case (TRACE[i][69:38])
        32'd64: chk("R7", "jal jump", {31'd0, ctl_jump}, 32'd1);
        32'd72: chk("R7", "j jump", {31'd0, ctl_jump}, 32'd1);
        32'd80: begin
          chk("R8", "jr flag", {31'd0, ctl_jreg}, 32'd1);
          chk("R8", "jr rs_value", rs_value, 32'd68);
        end
        32'd88: begin
          chk("R10", "beq branch", {31'd0, ctl_branch}, 32'd1);
          chk("R10", "beq zero", {31'd0, alu_zero}, 32'd1);
        end
        32'd92: begin
          chk("R10", "bne branch", {31'd0, ctl_branch}, 32'd1);
          chk("R10", "bne zero", {31'd0, alu_zero}, 32'd0);
        end
        32'd96: chk("R11", "no ctl", {29'd0, ctl_branch, ctl_jump, ctl_jreg}, 32'd0);
        default: ;
      endcase
    end
    @(negedge clk); #1;
    chk("R2", "pc after unknown", pc, 32'd100);

    // reset in the middle of a run
    rst_n = 1'b0;
    #1 chk("R1", "pc mid-run reset", pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1", "wb after reset", wb_data, 32'd5);
    @(negedge clk); #1;
    chk("R2", "pc restarts", pc, 32'd4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule